// File: doc/BRIEF.md
# Digital Clock Synthesizer with Dejitter Loop

This block builds a clean clock-enable stream from a jittery reference. It runs entirely on a fast system clock. One of four reference sources arrives as single-cycle enable pulses: the transmit clock, the receive data clock, an external master clock or the local internal clock. A programmable divider brings the chosen reference down to an 8 kHz comparison rate. A phase accumulator generates the output stream, and a second divider brings that stream down to the same 8 kHz rate.

At every reference comparison the position of the output divider is read as a signed phase error. That error feeds a single-pole recursive filter with a programmable right-shift gain, which sets the corner frequency. The filter produces a signed correction, clamped to about ±200 ppm of the nominal tuning word, and the correction is added to that word to steer the accumulator. A lock flag reports a long run of small errors.

All pins are plain control or status signals. The reference pulses are sampled on every cycle, so there is no handshake and no back-pressure: a pulse is consumed in the cycle it is present. Reference and output rates are both set in 8 kHz steps, so the two divider values are the rate divided by 8 kHz.

Top module: `clk_synth_dejitter`

## Requirements
- R1: Only pulses on the source picked by `ref_sel` advance the reference divider (0 transmit, 1 receive data, 2 external master, 3 local); pulses on the other three sources have no effect on `cmp_valid`, `phase_err` or `correction`.
- R2: A comparison occurs on every `ref_div`-th selected pulse. `cmp_valid` is high for the one cycle after the edge that takes that pulse.
- R3: With zero correction, `clk_en_out` is a registered carry of a 24-bit accumulator that adds `nominal_word` each cycle from zero after reset. Over the first M cycles it pulses floor(M·word/2^24) times.
- R4: `clk_out` is the accumulator MSB. Its high-cycle count over M cycles equals the number of i in 1..M with (i·word mod 2^24) ≥ 2^23, and it lies within 45–55 % whenever word ≤ 2^24/20.
- R5: The output divider counts `clk_en_out` pulses modulo `out_div`.
- R6: At a comparison, `phase_err` takes the output divider count c as c when 2c < `out_div`, and c − `out_div` otherwise.
- R7: At a comparison, `correction` becomes c + ((t − c) >>> `loop_shift`). Here c is the old correction, t = −16·error, and >>> is an arithmetic shift. The accumulator then adds `nominal_word` + `correction`.
- R8: `correction` is clamped to ±floor(`nominal_word`·13/65536).
- R9: `locked` rises at the 64th consecutive comparison with |error| ≤ `lock_window`, and it clears at any comparison outside that window.
- R10: A change of `ref_sel`, `ref_div`, `out_div` or `nominal_word` clears both dividers, `correction`, `phase_err`, `cmp_valid`, the run count and `locked` on the next edge, and the pulse in that cycle is ignored.
- R11: During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_sel | input | 2 | Reference source select |
| src_pulse | input | 4 | Enable pulses of the four reference sources |
| ref_div | input | 11 | Reference rate / 8 kHz |
| out_div | input | 11 | Output rate / 8 kHz |
| nominal_word | input | 24 | Nominal accumulator tuning word |
| loop_shift | input | 5 | Loop filter gain as right shift |
| lock_window | input | 11 | Largest error magnitude counted as in lock |
| clk_en_out | output | 1 | Synthesized clock enable |
| clk_out | output | 1 | Synthesized clock level |
| cmp_valid | output | 1 | Comparison strobe |
| phase_err | output | 12 | Signed phase error of the last comparison |
| correction | output | 16 | Signed tuning correction |
| locked | output | 1 | Lock indicator |

## Verification
A selected pulse taken at edge k shows up in `cmp_valid`, `phase_err`, `correction` and `locked` just after that same edge. The error uses the output divider count as it stood before edge k, which reflects the `clk_en_out` pulses observed up to the previous sample. The bench therefore keeps a model that is stepped once per clock: it drives at the falling edge, applies the edge in its model, and compares all four outputs at the next falling edge. A configuration change clears everything on the first edge after it, and the model clears on that same step. The accumulator results are due one edge after each addition, so carry and MSB counts over the first M samples after reset are compared with closed-form sums.

// File: rtl/cds_pkg.sv
package cds_pkg;
  typedef enum logic [1:0] {
    SRC_TX_CLK     = 2'd0,
    SRC_RX_DATA    = 2'd1,
    SRC_EXT_MASTER = 2'd2,
    SRC_LOCAL      = 2'd3
  } ref_src_e;

  localparam int NUM_SRC   = 4;
  // 13/65536 of the nominal word is just under 200 ppm
  localparam int PPM_NUM   = 13;
  localparam int PPM_SHIFT = 16;
endpackage

// File: rtl/cds_ref_divider.sv
module cds_ref_divider
  import cds_pkg::*;
#(
  parameter int DIV_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  ref_src_e           sel,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic [DIV_W-1:0]   div,
  output logic               ref_event
);
  logic [NUM_SRC-1:0] hits;
  logic               pick;
  logic [DIV_W-1:0]   cnt;
  logic               last;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hits[g] = src_pulse[g] && (sel == ref_src_e'(g));
  end

  assign pick      = |hits;
  assign last      = ({1'b0, cnt} + (DIV_W+1)'(1)) >= {1'b0, div};
  assign ref_event = pick && last && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (pick)   cnt <= last ? '0 : cnt + DIV_W'(1);
  end

  assert_refcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (div != '0 && !clear) |-> (cnt < div));
endmodule

// File: rtl/cds_nco.sv
module cds_nco #(
  parameter int ACC_W = 24,
  parameter int DIV_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [ACC_W-1:0] tune,
  input  logic [DIV_W-1:0] out_div,
  output logic             en,
  output logic             level,
  output logic [DIV_W-1:0] out_cnt
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;
  logic             wrap;

  assign sum   = {1'b0, acc} + {1'b0, tune};
  assign level = acc[ACC_W-1];
  assign wrap  = ({1'b0, out_cnt} + (DIV_W+1)'(1)) >= {1'b0, out_div};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      en  <= 1'b0;
    end else begin
      acc <= sum[ACC_W-1:0];
      en  <= sum[ACC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_cnt <= '0;
    else if (clear)  out_cnt <= '0;
    else if (en)     out_cnt <= wrap ? '0 : out_cnt + DIV_W'(1);
  end

  assert_carry_leaves_remainder_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (acc < $past(tune)));
  assert_outcnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_div != '0 && !clear) |-> (out_cnt < out_div));
endmodule

// File: rtl/cds_loop.sv
module cds_loop
  import cds_pkg::*;
#(
  parameter int ACC_W     = 24,
  parameter int DIV_W     = 11,
  parameter int CORR_W    = 16,
  parameter int SH_W      = 5,
  parameter int KP_SHIFT  = 4,
  parameter int LOCK_RUNS = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     cmp_event,
  input  logic [DIV_W-1:0]         out_cnt,
  input  logic [DIV_W-1:0]         out_div,
  input  logic [DIV_W-1:0]         window,
  input  logic [ACC_W-1:0]         nominal,
  input  logic [SH_W-1:0]          shift,
  output logic signed [DIV_W:0]    phase_err,
  output logic                     cmp_valid,
  output logic signed [CORR_W-1:0] correction,
  output logic                     locked
);
  localparam int EW  = DIV_W + 1;
  localparam int TW  = EW + KP_SHIFT;
  localparam int AW  = ((TW > CORR_W) ? TW : CORR_W) + 2;
  localparam int PW  = ACC_W + 5;
  localparam int LCW = $clog2(LOCK_RUNS + 1);

  logic signed [EW-1:0] err;
  logic        [EW-1:0] mag;
  logic                 in_win;
  logic        [PW-1:0] prod;
  logic signed [AW-1:0] lim, err_x, corr_x, target, diff, stepv, raw, nxt;
  logic       [LCW-1:0] runs;
  logic         [LCW:0] runs_inc;

  // phase detector: divider position folded into a signed range
  always_comb begin
    if ({out_cnt, 1'b0} < {1'b0, out_div}) err = $signed({1'b0, out_cnt});
    else err = $signed({1'b0, out_cnt}) - $signed({1'b0, out_div});
    mag    = err[EW-1] ? $unsigned(-err) : $unsigned(err);
    in_win = mag <= {1'b0, window};
  end

  // single-pole filter toward a proportional target, then clamp
  always_comb begin
    prod   = {5'b0, nominal} * PW'(PPM_NUM);
    lim    = $signed(AW'(prod >> PPM_SHIFT));
    err_x  = {{(AW-EW){err[EW-1]}}, err};
    corr_x = {{(AW-CORR_W){correction[CORR_W-1]}}, correction};
    target = -(err_x <<< KP_SHIFT);
    diff   = target - corr_x;
    stepv  = diff >>> shift;
    raw    = corr_x + stepv;
    if (raw > lim)       nxt = lim;
    else if (raw < -lim) nxt = -lim;
    else                 nxt = raw;
  end

  assign runs_inc = {1'b0, runs} + (LCW+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || clear) begin
      phase_err  <= '0;
      cmp_valid  <= 1'b0;
      correction <= '0;
      runs       <= '0;
      locked     <= 1'b0;
    end else begin
      cmp_valid <= cmp_event;
      if (cmp_event) begin
        phase_err  <= err;
        correction <= nxt[CORR_W-1:0];
        if (in_win) begin
          if (runs != LCW'(LOCK_RUNS)) runs <= runs + LCW'(1);
          locked <= runs_inc >= (LCW+1)'(LOCK_RUNS);
        end else begin
          runs   <= '0;
          locked <= 1'b0;
        end
      end
    end
  end

  logic [EW-1:0] pmag;
  assign pmag = phase_err[EW-1] ? $unsigned(-phase_err) : $unsigned(phase_err);

  assert_err_half_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !clear) |-> ({pmag, 1'b0} <= {2'b0, out_div}));
  assert_corr_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> (corr_x <= lim && corr_x >= -lim));
  assert_lock_after_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(runs) == LCW'(LOCK_RUNS - 1)));
  assert_clear_zeroes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (correction == '0 && !locked && !cmp_valid));
endmodule

// File: rtl/clk_synth_dejitter.sv
module clk_synth_dejitter
  import cds_pkg::*;
#(
  parameter int ACC_W     = 24,
  parameter int DIV_W     = 11,
  parameter int CORR_W    = 16,
  parameter int SH_W      = 5,
  parameter int KP_SHIFT  = 4,
  parameter int LOCK_RUNS = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               ref_sel,
  input  logic [3:0]               src_pulse,
  input  logic [DIV_W-1:0]         ref_div,
  input  logic [DIV_W-1:0]         out_div,
  input  logic [ACC_W-1:0]         nominal_word,
  input  logic [SH_W-1:0]          loop_shift,
  input  logic [DIV_W-1:0]         lock_window,
  output logic                     clk_en_out,
  output logic                     clk_out,
  output logic                     cmp_valid,
  output logic signed [DIV_W:0]    phase_err,
  output logic signed [CORR_W-1:0] correction,
  output logic                     locked
);
  logic [1:0]       sel_q;
  logic [DIV_W-1:0] rdiv_q, odiv_q;
  logic [ACC_W-1:0] nom_q;
  logic             cfg_chg;
  logic             ref_event;
  logic [DIV_W-1:0] out_cnt;
  logic [ACC_W-1:0] tune;
  logic             sel_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      rdiv_q <= '0;
      odiv_q <= '0;
      nom_q  <= '0;
    end else begin
      sel_q  <= ref_sel;
      rdiv_q <= ref_div;
      odiv_q <= out_div;
      nom_q  <= nominal_word;
    end
  end

  assign cfg_chg = (ref_sel != sel_q) || (ref_div != rdiv_q) ||
                   (out_div != odiv_q) || (nominal_word != nom_q);
  assign tune    = nominal_word + {{(ACC_W-CORR_W){correction[CORR_W-1]}}, correction};
  assign sel_hit = src_pulse[ref_sel];

  cds_ref_divider #(.DIV_W(DIV_W)) u_ref (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cfg_chg),
    .sel       (ref_src_e'(ref_sel)),
    .src_pulse (src_pulse),
    .div       (ref_div),
    .ref_event (ref_event)
  );

  cds_nco #(.ACC_W(ACC_W), .DIV_W(DIV_W)) u_nco (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (cfg_chg),
    .tune    (tune),
    .out_div (out_div),
    .en      (clk_en_out),
    .level   (clk_out),
    .out_cnt (out_cnt)
  );

  cds_loop #(
    .ACC_W(ACC_W), .DIV_W(DIV_W), .CORR_W(CORR_W), .SH_W(SH_W),
    .KP_SHIFT(KP_SHIFT), .LOCK_RUNS(LOCK_RUNS)
  ) u_loop (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (cfg_chg),
    .cmp_event  (ref_event),
    .out_cnt    (out_cnt),
    .out_div    (out_div),
    .window     (lock_window),
    .nominal    (nominal_word),
    .shift      (loop_shift),
    .phase_err  (phase_err),
    .cmp_valid  (cmp_valid),
    .correction (correction),
    .locked     (locked)
  );

  assert_cmp_after_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> $past(sel_hit));
  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_n |-> (!clk_en_out && !cmp_valid && !locked && correction == '0));
endmodule

// File: tb/clk_synth_dejitter_test.sv
module clk_synth_dejitter_test;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        ref_sel = '0;
  logic [3:0]        src_pulse = '0;
  logic [10:0]       ref_div = 11'd1;
  logic [10:0]       out_div = 11'd4;
  logic [23:0]       nominal_word = 24'd2097152;
  logic [4:0]        loop_shift = 5'd2;
  logic [10:0]       lock_window = 11'd1;
  logic              clk_en_out, clk_out, cmp_valid, locked;
  logic signed [11:0] phase_err;
  logic signed [15:0] correction;

  int checks = 0, errors = 0;
  int m_ref, m_out, m_corr, m_err, m_runs;
  bit m_cmpv, m_lock, prev_en, pend_chg;
  int en_cnt, hi_cnt;
  logic [15:0] lf = 16'hACE1;

  clk_synth_dejitter uut (
    .clk(clk), .rst_n(rst_n), .ref_sel(ref_sel), .src_pulse(src_pulse),
    .ref_div(ref_div), .out_div(out_div), .nominal_word(nominal_word),
    .loop_shift(loop_shift), .lock_window(lock_window),
    .clk_en_out(clk_en_out), .clk_out(clk_out), .cmp_valid(cmp_valid),
    .phase_err(phase_err), .correction(correction), .locked(locked)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int err_of(input int c, input int d);
    return (2 * c < d) ? c : c - d;
  endfunction

  function automatic int lim_of(input int nom);
    return (nom * 13) >>> 16;
  endfunction

  function automatic int iabs(input int v);
    return v < 0 ? -v : v;
  endfunction

  task automatic zero_model();
    m_ref = 0; m_out = 0; m_corr = 0; m_err = 0; m_runs = 0;
    m_cmpv = 0; m_lock = 0;
  endtask

  // one clock: drive at falling edge, model the rising edge, compare at next falling edge
  task automatic cycle(input logic [3:0] p);
    int e, tgt, raw, lim;
    src_pulse = p;
    @(negedge clk);
    src_pulse = '0;
    if (pend_chg) begin
      zero_model();
      pend_chg = 0;
    end else begin
      m_cmpv = 0;
      if (p[ref_sel]) begin
        if (m_ref + 1 >= int'(ref_div)) begin m_ref = 0; m_cmpv = 1; end
        else m_ref++;
      end
      if (m_cmpv) begin
        e = err_of(m_out, int'(out_div));
        m_err = e;
        lim = lim_of(int'(nominal_word));
        tgt = -(e * 16);
        raw = m_corr + ((tgt - m_corr) >>> loop_shift);
        if (raw > lim) raw = lim;
        if (raw < -lim) raw = -lim;
        m_corr = raw;
        if (iabs(e) <= int'(lock_window)) begin
          if (m_runs + 1 >= 64) m_lock = 1;
          if (m_runs < 64) m_runs++;
        end else begin
          m_runs = 0; m_lock = 0;
        end
      end
      if (prev_en) m_out = (m_out + 1 >= int'(out_div)) ? 0 : m_out + 1;
    end
    en_cnt += int'(clk_en_out);
    hi_cnt += int'(clk_out);
    prev_en = clk_en_out;
    check(cmp_valid == m_cmpv, "R1,R2 cmp_valid", int'(cmp_valid), int'(m_cmpv));
    check(int'(phase_err) == m_err, "R5,R6 phase_err", int'(phase_err), m_err);
    check(int'(correction) == m_corr, "R7,R8 correction", int'(correction), m_corr);
    check(locked == m_lock, "R9 locked", int'(locked), int'(m_lock));
  endtask

  task automatic set_cfg(input int s, input int rd, input int od, input int nom);
    if (s != int'(ref_sel) || rd != int'(ref_div) || od != int'(out_div) ||
        nom != int'(nominal_word)) pend_chg = 1;
    ref_sel = 2'(s); ref_div = 11'(rd); out_div = 11'(od); nominal_word = 24'(nom);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!clk_en_out && !clk_out && !cmp_valid && !locked, "R11 reset outputs",
          int'({clk_en_out, clk_out, cmp_valid, locked}), 0);
    check(correction == 0 && phase_err == 0, "R11 reset values", int'(correction), 0);
    rst_n = 1'b1;
    zero_model();
    prev_en = 0;
    pend_chg = 1;
    en_cnt = 0;
    hi_cnt = 0;
  endtask

  function automatic logic [3:0] rnd();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[3:0] & lf[7:4];
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int words[6];
    longint hi_exp, w;
    int cnt_clamp;
    bit saw_unlock;
    words = '{524288, 600000, 777777, 2097152, 5592405, 8388608};
    @(negedge clk);

    // R3 / R4: accumulator rate and MSB level from reset, several words
    foreach (words[k]) begin
      ref_sel = 0; ref_div = 1; out_div = 4; loop_shift = 2; lock_window = 1;
      nominal_word = 24'(words[k]);
      do_reset();
      for (int i = 0; i < 1000; i++) cycle(4'b0000);
      w = longint'(words[k]);
      check(longint'(en_cnt) == (1000 * w) >> 24, "R3 enable count", en_cnt,
            int'((1000 * w) >> 24));
      hi_exp = 0;
      for (int i = 1; i <= 1000; i++) if (((longint'(i) * w) % 16777216) >= 8388608) hi_exp++;
      check(longint'(hi_cnt) == hi_exp, "R4 high count", hi_cnt, int'(hi_exp));
      if (words[k] <= 838860)
        check(hi_cnt * 100 >= 45 * 1000 && hi_cnt * 100 <= 55 * 1000, "R4 duty", hi_cnt, 500);
    end

    // R1 R2 R5 R6 R7: every source selection with random pulses on all sources
    loop_shift = 2; lock_window = 1;
    for (int s = 0; s < 4; s++) begin
      set_cfg(s, 3, 4, 2097152);
      for (int i = 0; i < 200; i++) cycle(rnd());
    end

    // R8: small nominal word and no filtering drive the clamp
    loop_shift = 0; lock_window = 0; cnt_clamp = 0;
    set_cfg(1, 1, 16, 262144);
    for (int i = 0; i < 400; i++) begin
      cycle(rnd());
      if (iabs(int'(correction)) == 52) cnt_clamp++;
    end
    check(cnt_clamp > 0, "R8 clamp reached", cnt_clamp, 1);

    // R9: lock with a wide window, loss with a zero window
    loop_shift = 3; lock_window = 2;
    set_cfg(2, 1, 4, 2097152);
    for (int i = 0; i < 160; i++) cycle((i % 2 == 0) ? 4'b0100 : 4'b0000);
    check(locked == 1'b1, "R9 lock after 64 in-window", int'(locked), 1);
    lock_window = 0; saw_unlock = 0;
    for (int i = 0; i < 100; i++) begin
      cycle((i % 3 == 0) ? 4'b0100 : 4'b0000);
      if (!locked) saw_unlock = 1;
    end
    check(saw_unlock, "R9 unlock on large error", int'(saw_unlock), 1);

    // R10: relock, then change the source
    lock_window = 2;
    for (int i = 0; i < 160; i++) cycle((i % 2 == 0) ? 4'b0100 : 4'b0000);
    check(locked == 1'b1, "R10 locked before change", int'(locked), 1);
    set_cfg(3, 1, 4, 2097152);
    cycle(4'b1111);
    check(correction == 0 && !locked && !cmp_valid, "R10 cleared by change",
          int'(correction), 0);
    for (int i = 0; i < 100; i++) cycle(rnd());

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule